// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator Array

This block multiplies signed 8-bit bytes from a group of two or four consecutive source vectors by unsigned 8-bit bytes from one shared source vector. Each product is widened to 32 bits and summed into rows of an internal accumulator array. The vector width `VL` is a parameter. A vector holds `VL/32` 32-bit lanes, and the array holds `VL/8` rows of `VL` bits. Every group of four consecutive rows is one quad group. Inside a quad group, row `i` collects the products of byte `i` of every lane.

The surrounding logic fills a 32-entry source register file through a write port. It then presents an already-decoded operation (group size, source indices, base-select field, offset bit) with a one-cycle start pulse. Each operation processes one accumulator row per cycle and ends with a one-cycle done pulse. A combinational debug port reads any accumulator row.

The block derives the first row of the first quad group from the selected 32-bit base value plus the offset. It reduces that sum modulo the section size and aligns it down to a multiple of four. Each further source vector of the group moves one section further down the array.

Top module: `mqa_accum_array`

## Requirements
- R1: A source byte from the first group is read as two's complement (0x80 = -128) and the matching byte of the shared vector as unsigned (0xFF = 255). Their product is sign-extended to 32 bits and added modulo 2^32 to the accumulator lane.
- R2: Within a quad group, row offset i (0..3) uses byte position 4*e+i of both operands (byte k at bits 8k+7:8k) and updates lane e (bits 32e+31:32e) of that row.
- R3: The section size S is ROWS/2 when `quad_i`=0 and ROWS/4 when `quad_i`=1, where ROWS=VL/8. The first row is ((B + 4*`off_i`) mod 2^32 mod S) rounded down to a multiple of 4. B is the 32-bit slice `base_regs_i[32*k+31:32*k]` with k=`base_sel_i`.
- R4: Group member r (0..nreg-1) reads source register (`zn_i`+r) mod 32 and updates the quad group that starts r*S rows after the first row.
- R5: The shared vector is source register `zm_i`, a 4-bit index that reaches registers 0 to 15 only.
- R6: All lanes of the 4*nreg addressed rows are updated, and every other row keeps its value.
- R7: `done_o` goes high exactly 4*nreg clock edges after the edge that samples `start_i`, independent of data, and stays high for one cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored and does not change the running operation's result or latency.
- R9: After reset all accumulator rows read zero, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_we_i | input | 1 | Source register write enable |
| src_waddr_i | input | 5 | Source register write index |
| src_wdata_i | input | VL | Source register write data |
| base_regs_i | input | 128 | Four 32-bit base-select values, value k in bits 32k+31:32k |
| start_i | input | 1 | One-cycle start of an operation |
| quad_i | input | 1 | 0: group of two source vectors, 1: group of four |
| zn_i | input | 5 | First register of the signed source group |
| zm_i | input | 4 | Shared unsigned source register |
| base_sel_i | input | 2 | Picks one of the four base values |
| off_i | input | 1 | Offset bit, adds 4 to the base |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after the last row write |
| dbg_row_i | input | log2(VL/8) | Accumulator row to read |
| dbg_data_o | output | VL | Contents of the row picked by `dbg_row_i` |

## Verification
The bench builds the block with VL=128: 4 lanes and 16 rows, so a pair uses two sections of 8 rows and a quad group uses four sections of 4 rows. At this width a four-vector operation covers the whole array. A base value of all ones makes the 32-bit wrap and the modulo step visible, and a first group index of 30 or 31 crosses the register-file wrap. One shared register filled with 0xFF and one first-group register filled with 0x80 give the extreme product. The bench compares every row after every operation, so writes that go outside the target rows are caught.

// File: rtl/mqa_pkg.sv
package mqa_pkg;
   typedef struct packed {
      logic       quad;
      logic [4:0] zn;
      logic [3:0] zm;
   } mqa_op_t;

   localparam int unsigned MQA_NSRC = 32;
   localparam int unsigned MQA_BASE_W = 32;
   localparam int unsigned MQA_NBASE = 4;
endpackage

// File: rtl/mqa_srcfile.sv
module mqa_srcfile #(
   parameter int unsigned VL = 128,
   parameter int unsigned NSRC = mqa_pkg::MQA_NSRC,
   localparam int unsigned IDX_W = $clog2(NSRC)
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [IDX_W-1:0] waddr_i,
   input  logic [VL-1:0]    wdata_i,
   input  logic [IDX_W-1:0] ra_idx_i,
   output logic [VL-1:0]    ra_data_o,
   input  logic [3:0]       rb_idx_i,
   output logic [VL-1:0]    rb_data_o
);
   logic [VL-1:0] regs_q [NSRC];

   always_ff @(posedge clk) begin
      if (we_i) regs_q[waddr_i] <= wdata_i;
   end

   assign ra_data_o = regs_q[ra_idx_i];
   assign rb_data_o = regs_q[IDX_W'(rb_idx_i)];
endmodule

// File: rtl/mqa_seq.sv
module mqa_seq
   import mqa_pkg::*;
#(
   parameter int unsigned ROWS = 16,
   localparam int unsigned ROW_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  mqa_op_t          op_i,
   input  logic [31:0]      base_i,
   input  logic             off_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [ROW_W-1:0] row_o,
   output logic [1:0]       bytesel_o,
   output logic [4:0]       src_a_o,
   output logic [3:0]       src_b_o
);
   localparam logic [ROW_W-1:0] PAIR_S = ROW_W'(ROWS / 2);
   localparam logic [ROW_W-1:0] QUAD_S = ROW_W'(ROWS / 4);

   mqa_op_t          op_q;
   logic [ROW_W-1:0] first_q;
   logic [1:0]       r_q, i_q;
   logic             busy_q, done_q;
   logic [31:0]      sum;
   logic [ROW_W-1:0] first_d, stride, stride_d;
   logic             last;

   always_comb begin
      sum      = base_i + {29'd0, off_i, 2'b00};
      stride_d = op_i.quad ? QUAD_S : PAIR_S;
      first_d  = sum[ROW_W-1:0] & (stride_d - ROW_W'(1));
      first_d  = first_d & ~ROW_W'(3);
   end

   assign stride = op_q.quad ? QUAD_S : PAIR_S;
   assign last   = (i_q == 2'd3) && (r_q == (op_q.quad ? 2'd3 : 2'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         op_q    <= '0;
         first_q <= '0;
         r_q     <= '0;
         i_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q  <= 1'b1;
               op_q    <= op_i;
               first_q <= first_d;
               r_q     <= '0;
               i_q     <= '0;
            end
         end else if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else if (i_q == 2'd3) begin
            r_q <= r_q + 2'd1;
            i_q <= '0;
         end else begin
            i_q <= i_q + 2'd1;
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign row_o     = first_q + ROW_W'(r_q) * stride + ROW_W'(i_q);
   assign bytesel_o = i_q;
   assign src_a_o   = op_q.zn + 5'(r_q);
   assign src_b_o   = op_q.zm;

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !last) |=> ($stable(op_q) && $stable(first_q)));
   assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && i_q == 2'd3 && !last) |=> (src_a_o == $past(src_a_o) + 5'd1));
   assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && i_q == 2'd3 && !last) |=> (row_o == $past(row_o) - ROW_W'(3) + stride));
   assert_row_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && i_q == 2'd0) |-> (row_o[1:0] == 2'b00));
endmodule

// File: rtl/mqa_lanes.sv
module mqa_lanes #(
   parameter int unsigned VL = 128,
   localparam int unsigned LANES = VL / 32
) (
   input  logic [VL-1:0] a_vec_i,
   input  logic [VL-1:0] b_vec_i,
   input  logic [1:0]    bytesel_i,
   input  logic [VL-1:0] acc_i,
   output logic [VL-1:0] acc_o
);
   for (genvar e = 0; e < LANES; e++) begin : g_lane
      logic [7:0]        a_byte, b_byte;
      logic signed [16:0] prod;
      logic [31:0]        prod_w;

      assign a_byte = a_vec_i[(4*e)*8 + 8*bytesel_i +: 8];
      assign b_byte = b_vec_i[(4*e)*8 + 8*bytesel_i +: 8];
      assign prod   = $signed(a_byte) * $signed({1'b0, b_byte});
      assign prod_w = {{15{prod[16]}}, prod};
      assign acc_o[32*e +: 32] = acc_i[32*e +: 32] + prod_w;
   end
endmodule

// File: rtl/mqa_accum_array.sv
module mqa_accum_array
   import mqa_pkg::*;
#(
   parameter int unsigned VL = 128,
   localparam int unsigned ROWS = VL / 8,
   localparam int unsigned ROW_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_we_i,
   input  logic [4:0]       src_waddr_i,
   input  logic [VL-1:0]    src_wdata_i,
   input  logic [127:0]     base_regs_i,
   input  logic             start_i,
   input  logic             quad_i,
   input  logic [4:0]       zn_i,
   input  logic [3:0]       zm_i,
   input  logic [1:0]       base_sel_i,
   input  logic             off_i,
   output logic             busy_o,
   output logic             done_o,
   input  logic [ROW_W-1:0] dbg_row_i,
   output logic [VL-1:0]    dbg_data_o
);
   if ((VL % 32) != 0 || VL < 128 || (VL & (VL - 1)) != 0) begin : g_bad_vl
      $error("mqa_accum_array: VL must be a power of two of at least 128");
   end

   mqa_op_t          op;
   logic [31:0]      base_val;
   logic [ROW_W-1:0] row;
   logic [1:0]       bytesel;
   logic [4:0]       src_a;
   logic [3:0]       src_b;
   logic [VL-1:0]    a_vec, b_vec, acc_rd, acc_wr;
   logic [VL-1:0]    acc_q [ROWS];

   assign op       = '{quad: quad_i, zn: zn_i, zm: zm_i};
   assign base_val = base_regs_i[32*base_sel_i +: 32];

   mqa_srcfile #(.VL(VL)) u_src (
      .clk(clk), .we_i(src_we_i), .waddr_i(src_waddr_i), .wdata_i(src_wdata_i),
      .ra_idx_i(src_a), .ra_data_o(a_vec), .rb_idx_i(src_b), .rb_data_o(b_vec)
   );

   mqa_seq #(.ROWS(ROWS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op), .base_i(base_val),
      .off_i(off_i), .busy_o(busy_o), .done_o(done_o), .row_o(row),
      .bytesel_o(bytesel), .src_a_o(src_a), .src_b_o(src_b)
   );

   assign acc_rd = acc_q[row];

   mqa_lanes #(.VL(VL)) u_lanes (
      .a_vec_i(a_vec), .b_vec_i(b_vec), .bytesel_i(bytesel),
      .acc_i(acc_rd), .acc_o(acc_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < ROWS; k++) acc_q[k] <= '0;
      end else if (busy_o) begin
         acc_q[row] <= acc_wr;
      end
   end

   assign dbg_data_o = acc_q[dbg_row_i];

   assert_idle_rows_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !$past(busy_o)) |-> $stable(acc_q[dbg_row_i]) || $changed(dbg_row_i));
endmodule

// File: tb/mqa_accum_array_tb.sv
module mqa_accum_array_tb;
   localparam int VL = 128;
   localparam int LANES = VL / 32;
   localparam int ROWS = VL / 8;

   logic clk = 0, rst_n = 0;
   logic src_we = 0;
   logic [4:0] src_waddr = 0;
   logic [VL-1:0] src_wdata = 0;
   logic [127:0] base_regs = 0;
   logic start = 0, quad = 0, off = 0;
   logic [4:0] zn = 0;
   logic [3:0] zm = 0;
   logic [1:0] bsel = 0;
   logic busy, done;
   logic [3:0] dbg_row = 0;
   logic [VL-1:0] dbg_data;

   int checks = 0, errors = 0;
   int ops_sent = 0, ops_seen = 0;

   logic [VL-1:0] ref_src [32];
   logic [VL-1:0] ref_acc [ROWS];
   logic [ROWS*VL-1:0] exp_q [$];
   string tag_q [$];

   always #10 clk = ~clk;

   mqa_accum_array #(.VL(VL)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_we_i(src_we), .src_waddr_i(src_waddr),
      .src_wdata_i(src_wdata), .base_regs_i(base_regs), .start_i(start),
      .quad_i(quad), .zn_i(zn), .zm_i(zm), .base_sel_i(bsel), .off_i(off),
      .busy_o(busy), .done_o(done), .dbg_row_i(dbg_row), .dbg_data_o(dbg_data)
   );

   task automatic check(input string tag, input logic [VL-1:0] got, input logic [VL-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wsrc(input int idx, input logic [VL-1:0] d);
      @(negedge clk);
      src_we = 1; src_waddr = 5'(idx); src_wdata = d;
      @(negedge clk);
      src_we = 0;
      ref_src[idx] = d;
   endtask

   // Reference model built from R1..R4, R6.
   task automatic model(input logic q, input int n, input int m, input int sel, input logic o);
      int nreg, stride, first;
      logic [31:0] b, s;
      nreg = q ? 4 : 2;
      stride = ROWS / nreg;
      b = base_regs[32*sel +: 32];
      s = b + (o ? 32'd4 : 32'd0);
      first = int'(s % 32'(stride));
      first = first - (first % 4);
      for (int r = 0; r < nreg; r++)
         for (int i = 0; i < 4; i++)
            for (int e = 0; e < LANES; e++) begin
               int a, bb, row;
               logic [31:0] lane;
               row = first + r * stride + i;
               a = int'($signed(ref_src[(n + r) % 32][(4*e+i)*8 +: 8]));
               bb = int'(ref_src[m][(4*e+i)*8 +: 8]);
               lane = ref_acc[row][32*e +: 32];
               lane = lane + 32'(a * bb);
               ref_acc[row][32*e +: 32] = lane;
            end
   endtask

   task automatic run_op(input string tag, input logic q, input int n, input int m,
                         input int sel, input logic o, input bit interfere);
      logic [ROWS*VL-1:0] snap;
      int cnt;
      model(q, n, m, sel, o);
      for (int k = 0; k < ROWS; k++) snap[k*VL +: VL] = ref_acc[k];
      exp_q.push_back(snap);
      tag_q.push_back(tag);
      ops_sent++;
      @(negedge clk);
      start = 1; quad = q; zn = 5'(n); zm = 4'(m); bsel = 2'(sel); off = o;
      @(posedge clk);
      @(negedge clk);
      start = 0;
      cnt = 0;
      while (!done && cnt < 100) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (interfere && cnt == 3) begin
            start = 1; quad = ~q; zn = 5'(n + 7); zm = 4'(m + 1); bsel = 2'(sel + 1); off = ~o;
         end else begin
            start = 0;
         end
      end
      checks++;
      if (cnt != 4 * (q ? 4 : 2)) begin
         errors++;
         $display("FAIL R7 %s latency got %0d exp %0d", tag, cnt, 4 * (q ? 4 : 2));
      end
      @(negedge clk);
      checks++;
      if (done !== 1'b0) begin
         errors++;
         $display("FAIL R7 %s done width got 1 exp 0", tag);
      end
      wait (ops_seen == ops_sent);
   endtask

   // Monitor: pops the expected array at every done pulse and compares all rows.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            logic [ROWS*VL-1:0] snap;
            string tag;
            snap = exp_q.pop_front();
            tag = tag_q.pop_front();
            for (int k = 0; k < ROWS; k++) begin
               dbg_row = 4'(k);
               #1;
               check($sformatf("%s R6 row %0d", tag, k), dbg_data, snap[k*VL +: VL]);
            end
            ops_seen++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < ROWS; k++) ref_acc[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R9: reset state
      check("R9 busy", VL'(busy), '0);
      check("R9 done", VL'(done), '0);
      for (int k = 0; k < ROWS; k++) begin
         dbg_row = 4'(k);
         #1;
         check($sformatf("R9 row %0d", k), dbg_data, '0);
      end
      for (int k = 0; k < 32; k++) begin
         logic [VL-1:0] d;
         for (int j = 0; j < VL / 8; j++) d[8*j +: 8] = 8'(k * 37 + j * 11 + 5);
         wsrc(k, d);
      end
      wsrc(15, {(VL/8){8'hFF}});   // R5/R1: all 255 in shared register 15
      wsrc(31, {(VL/8){8'h80}});   // R1: all -128 in register 31
      base_regs = {32'hFFFF_FFFF, 32'h0000_0007, 32'h0000_0003, 32'h0000_0010};
      // R2: pair, base 3 -> first row 0, rows 0-3 and 8-11
      run_op("R2 pair", 1'b0, 2, 5, 1, 1'b0, 0);
      // R3/R4: quad, base 7+4=11 mod 4 -> 0, registers 30,31,0,1
      run_op("R3 quad", 1'b1, 30, 15, 2, 1'b1, 0);
      // R1/R4/R5: pair, base all ones mod 8 = 7 -> first row 4, wrap 31->0
      run_op("R1 wrap", 1'b0, 31, 15, 3, 1'b0, 0);
      // R3: pair, base 0x10 + 4 -> first row 4
      run_op("R3 offset", 1'b0, 9, 3, 0, 1'b1, 0);
      // R8: second start during run is ignored
      run_op("R8 restart", 1'b0, 12, 7, 1, 1'b1, 1);
      run_op("R6 quad2", 1'b1, 4, 11, 0, 1'b0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule